// File: doc/BRIEF.md
# Flash Operation Status Tracker

This block sits beside the core of an embedded flash controller and keeps the status of program and erase operations. Each operation arrives as a one-cycle request. The request carries the kind of operation, whether the target page is write-protected, whether the bus write data was misaligned, and the word currently stored at the target. The block screens the request before the flash array is started. A clean request raises busy and sends a one-cycle start pulse to the array. A request that fails any screen is dropped: the array is not started, and each failing cause is recorded in its own flag.

The flash array is modelled by a single completion pulse. When that pulse arrives, busy drops and the end-of-operation flag is set. Software reads the flags through a 32-bit status word and clears them by writing 1 to each flag. The word also shows whether the flash is in a low-power state.

Top module: `fst_status_tracker`

## Requirements
- R1: After a synchronous reset, busy and array_start are 0 and the status word reads 0x0000_0000.
- R2: A request taken while idle that fails no screen sets busy (status bit 0) and pulses array_start for exactly one cycle. Both outputs change on the clock edge that samples the request.
- R3: An array_done pulse while busy clears busy and sets the end flag (bit 5) on the same edge. An array_done pulse while idle has no effect.
- R4: A request, program or erase, that targets a protected page sets bit 4. Busy stays 0, array_start stays 0 and the end flag is not set.
- R5: A program request with misaligned write data sets bit 3 and is aborted as in R4. Erase requests do not check alignment.
- R6: A program request (req_op = 0) whose current word at the target is not all ones sets bit 2 and is aborted. Erase requests (req_op = 1) do not check the current word.
- R7: A request that fails several screens sets every matching flag on the same edge.
- R8: A request that arrives while busy is ignored. Busy, array_start and every flag stay as they were.
- R9: Writing 1 to bits 2 to 5 clears those flags, and writing 0 leaves them unchanged. If hardware sets a flag on the same edge that software clears it, the flag ends up set.
- R10: The status word is reached only at offset 0x0C with a word-sized access (bus_size = 2). A write at any other offset or size changes nothing. A read at any other offset or size returns 0.
- R11: Bit 15 reads 1 while flash_sleep was 1 on the previous edge. Bits 1, 6 to 14 and 16 to 31 always read 0. Bit 0 cannot be written.
- R12: Read data appears on bus_rdata one cycle after the read is sampled, and bus_rdata is 0 in cycles without a matching read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle operation request |
| req_op | input | 1 | 0 = program, 1 = erase |
| req_protected | input | 1 | Target page is write-protected |
| req_misaligned | input | 1 | Write data alignment fault |
| req_cur_data | input | DATA_W | Word currently stored at the target |
| array_done | input | 1 | Flash array finished the operation |
| flash_sleep | input | 1 | Flash is in sleep or power-down |
| bus_addr | input | ADDR_W | Register offset |
| bus_size | input | 2 | Access size, 2 = 32-bit word |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| busy | output | 1 | Operation in progress |
| array_start | output | 1 | One-cycle start pulse to the array |

## Verification
The assertions check the following on every cycle: the start pulse only appears alongside busy, completion always drops busy, busy holds with no new start while a request is refused, and an aborted request never starts the array. They also check that the reserved bits read 0, that the end flag survives a clear on the same edge it is set, and that narrow writes leave the flags alone. The bench scenarios are needed to show the meaning of each flag: which screen maps to which bit, that erase skips the alignment and erased-word checks, that multiple faults combine, and the exact read values across offsets, sizes and the sleep input. The bench compares all of these against a behavioural model on every clock.

// File: rtl/fst_pkg.sv
package fst_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} fst_op_e;

  localparam int STAT_W      = 32;
  localparam int BIT_BUSY    = 0;
  localparam int BIT_PG      = 2;
  localparam int BIT_PGA     = 3;
  localparam int BIT_WP      = 4;
  localparam int BIT_END     = 5;
  localparam int BIT_SLEEP   = 15;
  localparam int N_FLAGS     = 4;
  localparam int N_ERR       = 3;
  localparam logic [1:0] SIZE_WORD = 2'd2;
endpackage

// File: rtl/fst_check.sv
module fst_check
  import fst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  fst_op_e           op,
  input  logic              prot,
  input  logic              misalign,
  input  logic [DATA_W-1:0] cur_data,
  output logic [N_ERR-1:0]  err
);
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  logic is_prog;
  assign is_prog = (op == OP_PROG);

  always_comb begin
    err    = '0;
    err[2] = prot;
    err[1] = is_prog && misalign;
    err[0] = is_prog && (cur_data != ERASED);
  end
endmodule

// File: rtl/fst_seq.sv
module fst_seq (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic err_any,
  input  logic array_done,
  output logic busy,
  output logic array_start,
  output logic take_err,
  output logic finish
);
  logic take_ok;

  assign take_err = req_valid && !busy && err_any;
  assign take_ok  = req_valid && !busy && !err_any;
  assign finish   = busy && array_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      array_start <= 1'b0;
    end else begin
      array_start <= take_ok;
      if (finish)       busy <= 1'b0;
      else if (take_ok) busy <= 1'b1;
    end
  end

  a_r2_start_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    array_start |-> busy);
  a_r3_done_drops_busy: assert property (@(posedge clk) disable iff (rst)
    busy && array_done |=> !busy);
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
    busy && !array_done |=> busy && !array_start);
  a_r4_abort_no_start: assert property (@(posedge clk) disable iff (rst)
    req_valid && !busy && err_any |=> !busy && !array_start);
endmodule

// File: rtl/fst_regs.sv
module fst_regs
  import fst_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_ERR-1:0]  set_err,
  input  logic              set_end,
  input  logic              busy,
  input  logic              sleep_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [STAT_W-1:0] bus_rdata
);
  logic [N_FLAGS-1:0] flags;
  logic [N_FLAGS-1:0] set_v, clr_v;
  logic               sleep_q, hit;
  logic [STAT_W-1:0]  status;
  logic               unused_wdata;

  assign unused_wdata = ^{bus_wdata[STAT_W-1:BIT_END+1], bus_wdata[BIT_PG-1:0]};
  assign hit   = (bus_size == SIZE_WORD) && (bus_addr == STAT_OFF);
  assign set_v = {set_end, set_err};
  assign clr_v = (bus_wr && hit) ? bus_wdata[BIT_END:BIT_PG] : '0;

  always_comb begin
    status                   = '0;
    status[BIT_BUSY]         = busy;
    status[BIT_END:BIT_PG]   = flags;
    status[BIT_SLEEP]        = sleep_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      sleep_q   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      flags     <= (flags & ~clr_v) | set_v;
      sleep_q   <= sleep_in;
      bus_rdata <= (bus_rd && hit) ? status : '0;
    end
  end

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    set_end |=> flags[N_FLAGS-1]);
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:16] == '0 && bus_rdata[14:6] == '0 && !bus_rdata[1]);
  a_r10_narrow_write_ignored: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_size != SIZE_WORD && set_v == '0 |=> flags == $past(flags));
endmodule

// File: rtl/fst_status_tracker.sv
module fst_status_tracker
  import fst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic              req_protected,
  input  logic              req_misaligned,
  input  logic [DATA_W-1:0] req_cur_data,
  input  logic              array_done,
  input  logic              flash_sleep,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              array_start
);
  logic [N_ERR-1:0] err;
  logic             take_err, finish;

  fst_check #(.DATA_W(DATA_W)) u_check (
    .op(fst_op_e'(req_op)), .prot(req_protected), .misalign(req_misaligned),
    .cur_data(req_cur_data), .err(err)
  );

  fst_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .err_any(|err),
    .array_done(array_done), .busy(busy), .array_start(array_start),
    .take_err(take_err), .finish(finish)
  );

  fst_regs #(.ADDR_W(ADDR_W), .STAT_OFF(ADDR_W'('h0C))) u_regs (
    .clk(clk), .rst(rst), .set_err(take_err ? err : '0), .set_end(finish),
    .busy(busy), .sleep_in(flash_sleep), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );
endmodule

// File: tb/test_fst_status_tracker.sv
module test_fst_status_tracker;
  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_op = 0, req_protected = 0, req_misaligned = 0;
  logic [15:0] req_cur_data = '1;
  logic        array_done = 0, flash_sleep = 0;
  logic [7:0]  bus_addr = 8'h0C;
  logic [1:0]  bus_size = 2;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        busy, array_start;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  fst_status_tracker i_fst_status_tracker (.*);

  // behavioural reference model
  bit m_busy, m_start, m_sleep;
  bit [3:0] m_flags;
  bit [31:0] m_rd;
  always @(posedge clk) begin
    bit [31:0] snap;
    bit [3:0] set, clr;
    bit word;
    if (rst) begin
      m_busy = 0; m_start = 0; m_sleep = 0; m_flags = 0; m_rd = 0;
    end else begin
      snap = 0; snap[0] = m_busy; snap[5:2] = m_flags; snap[15] = m_sleep;
      word = (bus_size == 2) && (bus_addr == 8'h0C);
      m_rd = (bus_rd && word) ? snap : 0;
      set = 0; m_start = 0;
      if (m_busy) begin
        if (array_done) begin m_busy = 0; set[3] = 1; end
      end else if (req_valid) begin
        set[2] = req_protected;
        set[1] = (req_op == 0) && req_misaligned;
        set[0] = (req_op == 0) && (req_cur_data != 16'hFFFF);
        if (set == 0) begin m_busy = 1; m_start = 1; end
      end
      clr = (bus_wr && word) ? bus_wdata[5:2] : 4'b0;
      m_flags = (m_flags & ~clr) | set;
      m_sleep = flash_sleep;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    check("R2 model busy", 32'(busy), 32'(m_busy));
    check("R2 model start", 32'(array_start), 32'(m_start));
    check("R12 model rdata", bus_rdata, m_rd);
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(bit op, bit prot, bit mis, logic [15:0] cur);
    req_valid = 1; req_op = op; req_protected = prot; req_misaligned = mis; req_cur_data = cur;
    cyc();
    req_valid = 0; req_protected = 0; req_misaligned = 0; req_cur_data = '1;
  endtask

  task automatic done();
    array_done = 1; cyc(); array_done = 0;
  endtask

  task automatic wr(logic [31:0] d, logic [7:0] a = 8'h0C, logic [1:0] s = 2);
    bus_wr = 1; bus_wdata = d; bus_addr = a; bus_size = s;
    cyc();
    bus_wr = 0; bus_addr = 8'h0C; bus_size = 2;
  endtask

  task automatic rd_chk(string tag, logic [31:0] exp, logic [7:0] a = 8'h0C, logic [1:0] s = 2);
    bus_rd = 1; bus_addr = a; bus_size = s;
    cyc();
    bus_rd = 0; bus_addr = 8'h0C; bus_size = 2;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    fork
      begin : wd
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
      begin
        cyc(3); rst = 0; cyc();
        check("R1 busy", 32'(busy), 0);
        rd_chk("R1 status after reset", 32'h0);
        // clean program
        req(0, 0, 0, 16'hFFFF);
        check("R2 busy set", 32'(busy), 1);
        check("R2 start pulse", 32'(array_start), 1);
        cyc();
        check("R2 start one cycle", 32'(array_start), 0);
        rd_chk("R2 busy in status", 32'h1);
        done();
        check("R3 busy cleared", 32'(busy), 0);
        rd_chk("R3 end flag", 32'h20);
        done();
        rd_chk("R3 idle done ignored", 32'h20);
        wr(32'h0);
        rd_chk("R9 write zero keeps", 32'h20);
        wr(32'h20);
        rd_chk("R9 write one clears", 32'h0);
        // protection on erase; current word ignored
        req(1, 1, 1, 16'h1234);
        check("R4 no busy", 32'(busy), 0);
        check("R4 no start", 32'(array_start), 0);
        rd_chk("R4 R6 erase protect only", 32'h10);
        wr(32'h10);
        req(0, 0, 1, 16'hFFFF);
        rd_chk("R5 misaligned", 32'h08);
        wr(32'h08);
        req(0, 0, 0, 16'h00FF);
        check("R6 no start", 32'(array_start), 0);
        rd_chk("R6 not erased", 32'h04);
        wr(32'h04);
        req(0, 1, 1, 16'h0000);
        rd_chk("R7 all errors", 32'h1C);
        wr(32'h3C);
        rd_chk("R9 clear all", 32'h0);
        // ignore while busy
        req(1, 0, 0, 16'h0000);
        check("R2 erase starts", 32'(busy), 1);
        req(0, 1, 1, 16'h0000);
        check("R8 no new start", 32'(array_start), 0);
        rd_chk("R8 flags untouched", 32'h1);
        // set beats clear on same edge
        array_done = 1; bus_wr = 1; bus_wdata = 32'h20; cyc();
        array_done = 0; bus_wr = 0;
        rd_chk("R9 set wins", 32'h20);
        wr(32'h20, 8'h0C, 2'd1);
        rd_chk("R10 narrow write ignored", 32'h20);
        wr(32'h20, 8'h08, 2'd2);
        rd_chk("R10 wrong offset write ignored", 32'h20);
        rd_chk("R10 narrow read zero", 32'h0, 8'h0C, 2'd1);
        rd_chk("R10 wrong offset read zero", 32'h0, 8'h10, 2'd2);
        wr(32'h20);
        flash_sleep = 1; cyc();
        rd_chk("R11 sleep bit", 32'h8000);
        wr(32'hFFFF_FFFF);
        rd_chk("R11 busy and reserved not writable", 32'h8000);
        flash_sleep = 0; cyc();
        rd_chk("R11 sleep cleared", 32'h0);
        cyc(2);
        disable wd;
      end
    join
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule